// File: doc/BRIEF.md
# Instruction address match interrupt unit

This unit watches the address of the instruction that is about to run. It raises an interrupt request when that address equals one of four programmable match addresses. Software loads each match address through its own write port. The enables for the four sources are held in two separate control registers: one holds the enables for sources 0 and 1, the other holds the enables for sources 2 and 3. The request has no masking input. The global interrupt-enable flag and the processor priority level never reach this unit, so nothing gates it apart from the per-source enables.

When a request fires, the unit also reports which source matched and the program counter value that the stack push must save. That value is not the true return address. It is the match address plus 2 when the decoder marks the instruction at that address as long-class: a 16-bit opcode, or one of a fixed group of short-form 8-bit-opcode instructions. For every other instruction it is the match address plus 1. No match is reported for fetches from an external area that is served by an 8-bit-wide bus. The instruction decoder, the stack push and the interrupt vectoring are outside this unit.

Top module: `addr_match_irq`

## Requirements
- R1: After reset `irq_req` is 0, `irq_src` is 0 and `saved_pc` is 0. Every match address resets to 0 and every enable resets to 0, so a fetch of address 0 straight after reset raises no request.
- R2: A write to a match address through `addr_wr_en`, `addr_wr_idx` and `addr_wr_data` is used only by fetches sampled on later clock edges. A fetch sampled on the same edge as the write is still compared against the old value.
- R3: `en_lo_wr` loads `en_wr_data` bit 0 into the enable for source 0 and bit 1 into the enable for source 1. `en_hi_wr` loads bit 0 into the enable for source 2 and bit 1 into the enable for source 3. A disabled source never raises a request.
- R4: `irq_req` is a one-cycle pulse in the cycle after each sampled edge where `fetch_valid` is 1 and `fetch_addr` equals an enabled match address. Two qualifying fetches in a row give two pulses in a row. A matching address presented with `fetch_valid` at 0 gives no pulse.
- R5: A fetch sampled with `ext_narrow` at 1 never raises a request, even when its address matches an enabled source.
- R6: When several enabled sources match at once, `irq_src` reports the lowest-numbered of them.
- R7: When `long_class` is 1 at the matching fetch, `saved_pc` becomes the fetch address plus 2, modulo 2^20.
- R8: When `long_class` is 0 at the matching fetch, `saved_pc` becomes the fetch address plus 1, modulo 2^20.
- R9: `saved_pc` and `irq_src` change only in a cycle where `irq_req` is 1. In every other cycle they keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the unit |
| addr_wr_en | input | 1 | Write strobe for one match address |
| addr_wr_idx | input | 2 | Source number of the match address being written |
| addr_wr_data | input | 20 | New match address |
| en_lo_wr | input | 1 | Load the enables for sources 0 and 1 |
| en_hi_wr | input | 1 | Load the enables for sources 2 and 3 |
| en_wr_data | input | 2 | Enable values: bit 0 is the lower source of the pair, bit 1 the upper |
| fetch_valid | input | 1 | The fetch address is valid in this cycle |
| fetch_addr | input | 20 | Address of the next instruction to run |
| long_class | input | 1 | From the decoder: 1 when the instruction is long-class |
| ext_narrow | input | 1 | 1 when the fetch address lies in an external area on an 8-bit bus |
| irq_req | output | 1 | One-cycle interrupt request pulse |
| irq_src | output | 2 | Number of the source that raised the last request |
| saved_pc | output | 20 | Program counter value to push for the last request |

## Verification
The bench builds the unit with its default parameters: a 20-bit address and two enables per control register, which gives four sources. With these values the whole top of the address space can be reached, so the saved-PC wrap from 0xFFFFF can be checked for both the plus-1 and the plus-2 case. With four sources, ties among all four comparators can be driven, so the priority order is checked through a full chain of fall-throughs. Directed phases cover the edge where a write and a fetch fall on the same clock, the way the two enable registers split the sources between them, and suppression of narrow-bus fetches. A random phase then drives fetches from a small address pool, mixed with writes to the match addresses and the enables.

// File: rtl/amu_pkg.sv
package amu_pkg;

  parameter int unsigned AMU_ADDR_W = 20;
  parameter int unsigned AMU_BANK_W = 2;

  // increment applied to a matched address before it is saved
  function automatic logic [1:0] amu_pc_step(input logic is_long);
    return is_long ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/amu_rst_sync.sv
module amu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/amu_match_bank.sv
module amu_match_bank #(
  parameter int unsigned ADDR_W = amu_pkg::AMU_ADDR_W,
  parameter int unsigned BANK_W = amu_pkg::AMU_BANK_W,
  parameter int unsigned NUM_SRC = 2 * BANK_W,
  parameter int unsigned IDX_W = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      addr_wr_en,
  input  logic [IDX_W-1:0]          addr_wr_idx,
  input  logic [ADDR_W-1:0]         addr_wr_data,
  input  logic                      en_lo_wr,
  input  logic                      en_hi_wr,
  input  logic [BANK_W-1:0]         en_wr_data,
  output logic [NUM_SRC*ADDR_W-1:0] match_addr,
  output logic [NUM_SRC-1:0]        src_en
);

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_src
      localparam int unsigned BANK_SEL = g / BANK_W;
      localparam int unsigned BANK_BIT = g % BANK_W;

      logic [ADDR_W-1:0] addr_q, addr_d;
      logic              addr_ce;
      logic              en_q, en_d, en_ce;

      always_comb begin
        addr_ce = addr_wr_en && (addr_wr_idx == IDX_W'(g));
        addr_d  = addr_wr_data;
        en_ce   = (BANK_SEL == 0) ? en_lo_wr : en_hi_wr;
        en_d    = en_wr_data[BANK_BIT];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          addr_q <= '0;
        end else if (addr_ce) begin
          addr_q <= addr_d;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q <= 1'b0;
        end else if (en_ce) begin
          en_q <= en_d;
        end
      end

      assign match_addr[g*ADDR_W +: ADDR_W] = addr_q;
      assign src_en[g] = en_q;
    end
  endgenerate

endmodule

// File: rtl/amu_select.sv
module amu_select #(
  parameter int unsigned ADDR_W = amu_pkg::AMU_ADDR_W,
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC*ADDR_W-1:0] match_addr,
  input  logic [NUM_SRC-1:0]        src_en,
  input  logic                      fetch_valid,
  input  logic [ADDR_W-1:0]         fetch_addr,
  input  logic                      ext_narrow,
  output logic                      hit,
  output logic [IDX_W-1:0]          hit_idx
);

  logic [NUM_SRC-1:0] eq;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_cmp
      assign eq[g] = src_en[g] && (match_addr[g*ADDR_W +: ADDR_W] == fetch_addr);
    end
  endgenerate

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit_idx = IDX_W'(i);
      end
    end
    hit = fetch_valid && !ext_narrow && (|eq);
  end

endmodule

// File: rtl/addr_match_irq.sv
module addr_match_irq #(
  parameter int unsigned ADDR_W = amu_pkg::AMU_ADDR_W,
  parameter int unsigned BANK_W = amu_pkg::AMU_BANK_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          addr_wr_en,
  input  logic [$clog2(2*BANK_W)-1:0]   addr_wr_idx,
  input  logic [ADDR_W-1:0]             addr_wr_data,
  input  logic                          en_lo_wr,
  input  logic                          en_hi_wr,
  input  logic [BANK_W-1:0]             en_wr_data,
  input  logic                          fetch_valid,
  input  logic [ADDR_W-1:0]             fetch_addr,
  input  logic                          long_class,
  input  logic                          ext_narrow,
  output logic                          irq_req,
  output logic [$clog2(2*BANK_W)-1:0]   irq_src,
  output logic [ADDR_W-1:0]             saved_pc
);

  localparam int unsigned NUM_SRC = 2 * BANK_W;
  localparam int unsigned IDX_W   = $clog2(NUM_SRC);

  logic                      rst_n_int;
  logic [NUM_SRC*ADDR_W-1:0] match_addr;
  logic [NUM_SRC-1:0]        src_en;
  logic                      hit;
  logic [IDX_W-1:0]          hit_idx;

  logic                      req_q, req_d;
  logic [IDX_W-1:0]          src_q, src_d;
  logic [ADDR_W-1:0]         pc_q, pc_d;
  logic                      out_ce;

  amu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  amu_match_bank #(
    .ADDR_W  (ADDR_W),
    .BANK_W  (BANK_W),
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W)
  ) u_bank (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .addr_wr_en   (addr_wr_en),
    .addr_wr_idx  (addr_wr_idx),
    .addr_wr_data (addr_wr_data),
    .en_lo_wr     (en_lo_wr),
    .en_hi_wr     (en_hi_wr),
    .en_wr_data   (en_wr_data),
    .match_addr   (match_addr),
    .src_en       (src_en)
  );

  amu_select #(
    .ADDR_W  (ADDR_W),
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W)
  ) u_sel (
    .match_addr  (match_addr),
    .src_en      (src_en),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .ext_narrow  (ext_narrow),
    .hit         (hit),
    .hit_idx     (hit_idx)
  );

  // a hit means fetch_addr equals the winning match address, so one adder
  // on the fetch address serves every source
  always_comb begin
    req_d  = hit;
    out_ce = hit;
    src_d  = hit_idx;
    pc_d   = fetch_addr + {{(ADDR_W-2){1'b0}}, amu_pkg::amu_pc_step(long_class)};
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      src_q <= '0;
      pc_q  <= '0;
    end else if (out_ce) begin
      src_q <= src_d;
      pc_q  <= pc_d;
    end
  end

  assign irq_req  = req_q;
  assign irq_src  = src_q;
  assign saved_pc = pc_q;

endmodule

// File: rtl/addr_match_irq_chk.sv
module addr_match_irq_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned BANK_W = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        fetch_valid,
  input logic [ADDR_W-1:0]           fetch_addr,
  input logic                        long_class,
  input logic                        ext_narrow,
  input logic                        irq_req,
  input logic [$clog2(2*BANK_W)-1:0] irq_src,
  input logic [ADDR_W-1:0]           saved_pc
);

  // R4: a pulse needs a valid fetch on the edge before it
  assert_req_needs_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(fetch_valid))
    else $error("R4 request without valid fetch");

  // R5: narrow-bus fetches never match
  assert_no_narrow_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !$past(ext_narrow))
    else $error("R5 request from narrow external fetch");

  // R7, R8: saved value is fetch address plus step chosen by class
  assert_saved_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (saved_pc == ($past(fetch_addr)
                 + {{(ADDR_W-2){1'b0}}, ($past(long_class) ? 2'd2 : 2'd1)})))
    else $error("R7/R8 saved pc mismatch");

  // R9: outputs hold between requests
  assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> ($stable(saved_pc) && $stable(irq_src)))
    else $error("R9 outputs changed without request");

endmodule

bind addr_match_irq addr_match_irq_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_valid (fetch_valid),
  .fetch_addr  (fetch_addr),
  .long_class  (long_class),
  .ext_narrow  (ext_narrow),
  .irq_req     (irq_req),
  .irq_src     (irq_src),
  .saved_pc    (saved_pc)
);

// File: tb/addr_match_irq_test.sv
`timescale 1ns/1ps
module addr_match_irq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_wr_en = 1'b0;
  logic [1:0]  addr_wr_idx = 2'd0;
  logic [19:0] addr_wr_data = 20'd0;
  logic        en_lo_wr = 1'b0;
  logic        en_hi_wr = 1'b0;
  logic [1:0]  en_wr_data = 2'd0;
  logic        fetch_valid = 1'b0;
  logic [19:0] fetch_addr = 20'd0;
  logic        long_class = 1'b0;
  logic        ext_narrow = 1'b0;
  logic        irq_req;
  logic [1:0]  irq_src;
  logic [19:0] saved_pc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural reference
  int exp_addr [4];
  bit exp_en [4];
  bit exp_irq;
  int exp_src;
  int exp_pc;

  always #10 clk = ~clk;

  addr_match_irq uut (
    .clk(clk), .rst_n(rst_n),
    .addr_wr_en(addr_wr_en), .addr_wr_idx(addr_wr_idx), .addr_wr_data(addr_wr_data),
    .en_lo_wr(en_lo_wr), .en_hi_wr(en_hi_wr), .en_wr_data(en_wr_data),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .long_class(long_class), .ext_narrow(ext_narrow),
    .irq_req(irq_req), .irq_src(irq_src), .saved_pc(saved_pc)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin exp_addr[i] = 0; exp_en[i] = 0; end
      exp_irq = 0; exp_src = 0; exp_pc = 0;
    end else begin
      int win;
      win = -1;
      if (fetch_valid && !ext_narrow)
        for (int i = 3; i >= 0; i--)
          if (exp_en[i] && exp_addr[i] == int'(fetch_addr)) win = i;
      exp_irq = (win >= 0);
      if (win >= 0) begin
        exp_src = win;
        exp_pc = (int'(fetch_addr) + (long_class ? 2 : 1)) % (1 << 20);
      end
      if (addr_wr_en) exp_addr[addr_wr_idx] = int'(addr_wr_data);
      if (en_lo_wr) begin exp_en[0] = en_wr_data[0]; exp_en[1] = en_wr_data[1]; end
      if (en_hi_wr) begin exp_en[2] = en_wr_data[0]; exp_en[3] = en_wr_data[1]; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (irq_req !== exp_irq || int'(irq_src) != exp_src || int'(saved_pc) != exp_pc) begin
        errors++;
        $display("FAIL %s: irq=%0b src=%0d pc=%05h expected irq=%0b src=%0d pc=%05h",
                 cur_req, irq_req, irq_src, saved_pc, exp_irq, exp_src, exp_pc);
      end
    end
  end

  task automatic idle();
    addr_wr_en = 0; en_lo_wr = 0; en_hi_wr = 0;
    fetch_valid = 0; long_class = 0; ext_narrow = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic wr_addr(input int idx, input int a);
    addr_wr_en = 1; addr_wr_idx = 2'(idx); addr_wr_data = 20'(a);
  endtask

  task automatic wr_en(input bit hi, input int v);
    if (hi) en_hi_wr = 1; else en_lo_wr = 1;
    en_wr_data = 2'(v);
  endtask

  task automatic fetch(input int a, input bit lng, input bit nar);
    fetch_valid = 1; fetch_addr = 20'(a); long_class = lng; ext_narrow = nar;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: directed reset check before any stimulus
    checks++;
    if (irq_req !== 1'b0 || irq_src !== 2'd0 || saved_pc !== 20'd0) begin
      errors++;
      $display("FAIL R1: irq=%0b src=%0d pc=%05h expected 0 0 00000", irq_req, irq_src, saved_pc);
    end
    repeat (3) tick();
    cur_req = "R1";
    fetch(0, 0, 0); tick(); tick();

    cur_req = "R2";
    wr_en(0, 1); tick();
    wr_addr(0, 'h12345); fetch('h12345, 0, 0); tick(); tick();
    fetch('h12345, 0, 0); tick(); tick();

    cur_req = "R3";
    wr_addr(1, 'h00100); tick();
    wr_addr(2, 'h00200); tick();
    wr_addr(3, 'h00300); tick();
    fetch('h00100, 0, 0); tick();
    fetch('h00200, 0, 0); tick();
    wr_en(1, 1); tick();
    fetch('h00200, 1, 0); tick();
    fetch('h00300, 0, 0); tick();
    wr_en(1, 2); tick();
    fetch('h00300, 1, 0); tick();
    fetch('h00200, 0, 0); tick();
    wr_en(0, 2); tick();
    fetch('h00100, 0, 0); tick();
    fetch('h12345, 0, 0); tick(); tick();

    cur_req = "R4";
    fetch_valid = 0; fetch_addr = 20'h00100; tick();
    fetch('h00100, 0, 0); tick();
    fetch('h00300, 1, 0); tick();
    fetch('h00100, 1, 0); tick(); tick();

    cur_req = "R5";
    fetch('h00100, 0, 1); tick();
    fetch('h00300, 1, 1); tick(); tick();

    cur_req = "R6";
    wr_en(0, 3); wr_en(1, 3); tick();
    for (int i = 0; i < 4; i++) begin wr_addr(i, 'h0ABCD); tick(); end
    fetch('h0ABCD, 0, 0); tick();
    wr_en(0, 2); tick();
    fetch('h0ABCD, 0, 0); tick();
    wr_en(0, 0); tick();
    fetch('h0ABCD, 1, 0); tick();
    wr_en(1, 2); tick();
    fetch('h0ABCD, 0, 0); tick(); tick();

    cur_req = "R7";
    wr_en(0, 3); wr_en(1, 3); tick();
    wr_addr(0, 'hFFFFF); wr_addr(0, 'hFFFFF); tick();
    fetch('hFFFFF, 1, 0); tick();
    fetch('h0ABCD, 1, 0); tick(); tick();

    cur_req = "R8";
    fetch('hFFFFF, 0, 0); tick();
    fetch('h0ABCD, 0, 0); tick(); tick();

    cur_req = "R9";
    fetch('h55555, 1, 0); tick();
    repeat (4) tick();

    cur_req = "R4/R6 random";
    for (int n = 0; n < 400; n++) begin
      int pool [4];
      pool[0] = 'h00010; pool[1] = 'h00020; pool[2] = 'hFFFFE; pool[3] = 'h00030;
      if ($urandom_range(0, 5) == 0) wr_addr($urandom_range(0, 3), pool[$urandom_range(0, 3)]);
      if ($urandom_range(0, 7) == 0) wr_en($urandom_range(0, 1), $urandom_range(0, 3));
      if ($urandom_range(0, 3) != 0)
        fetch(pool[$urandom_range(0, 3)], 1'($urandom_range(0, 1)), ($urandom_range(0, 4) == 0));
      tick();
    end
    tick();
    summary();
  end

endmodule